// File: doc/BRIEF.md
# SPI Flash Program and Erase Sequencer

This block sits on the host side of a serial NOR flash and turns one request into the full command exchange needed to change the array. A request asks for one of three things: program a run of bytes starting at a 24-bit address, erase the sector holding an address, or erase the whole device. The block wraps each modifying command in its own write-enable frame, cuts long program runs into pieces that never leave a 256-byte page, and after each modifying frame reads the flash status byte over and over until the busy flag drops.

Program data is pulled one byte at a time from a simple stream input: the block captures `data_in` and pulses `data_pop` one cycle later, so the host can present the next byte. The end of a request is signalled by a single-cycle `done` pulse, with `err` valid alongside it. The serial side is an SPI master in clock mode 0, and its bit rate is set by a clock-divider parameter.

Top module: `flash_wr_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle, and a request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_op` encodes 0 = program, 1 = sector erase, 2 = whole-array erase. The value 3 is rejected: it finishes with `done` and `err`=1 and puts no frame on the bus.
- R2: Each program frame and each erase frame comes straight after its own frame of exactly one byte, 06h.
- R3: A program frame is 02h, then the address (bits 23:16, 15:8, 7:0), then the data bytes in stream order. Each byte is captured from `data_in`, and `data_pop` goes high for one cycle on the next cycle.
- R4: No program frame crosses a 256-byte page boundary. A run that crosses one is sent as several write-enable plus program pairs. Each frame ends at the page end or at the end of the run, and the next frame starts at the following address.
- R5: A sector erase frame is D8h followed by the three address bytes, most significant first. A whole-array erase frame is the single byte C7h.
- R6: The bus uses SPI mode 0. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sclk` is low. Bytes go out most significant bit first, and `spi_miso` is sampled on rising clock edges. Every frame holds a whole number of bytes.
- R7: Between two frames, `spi_cs_n` stays high for at least 2*CLK_DIV system clock cycles, which is one SPI clock period.
- R8: After each program or erase frame, status frames (05h plus one read byte) repeat until bit 0 of the read byte is 0. The other status bits are ignored. The request then either continues with the next page or completes with `err`=0.
- R9: Within one wait, if `poll_max` status reads in a row return bit 0 high (a value of 0 counts as 1), the request ends with `err`=1 and no further frame is sent.
- R10: `done` is a single-cycle pulse. A program request with length 0 completes with `err`=0, sends no frame and pops no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | Operation code (see R1) |
| req_addr | input | 24 | Start address for program, or an address in the sector to erase |
| req_len | input | LEN_W | Number of bytes to program |
| poll_max | input | POLL_W | Limit on busy status reads in a row |
| data_in | input | 8 | Next program byte |
| data_pop | output | 1 | Pulse: the byte on data_in has been taken |
| done | output | 1 | Request finished (one-cycle pulse) |
| err | output | 1 | Request failed; valid with done |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume the following about the inputs:
- `data_in` already holds the next byte whenever the block may capture it.
- `poll_max` is stable for the whole of a request.
- `spi_miso` settles while the SPI clock is low.

The bench meets each of these:
- It offers requests only while `req_ready` is high.
- It moves `data_in` on the half cycle after each `data_pop`.
- It drives `spi_miso` from a flash model that shifts out the status byte on falling SPI clock edges, with random values in the ignored bits.
- It sets the number of busy reads per operation so that it is either below the poll limit or deliberately at or above it.

// File: rtl/fws_pkg.sv
package fws_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BULK = 2'd2,
        OP_BAD  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WREN,
        S_CMD,
        S_DATA,
        S_POLL_OP,
        S_POLL_RD,
        S_GAP,
        S_FIN
    } st_e;

    localparam logic [7:0] CMD_WREN = 8'h06;
    localparam logic [7:0] CMD_PP   = 8'h02;
    localparam logic [7:0] CMD_SE   = 8'hD8;
    localparam logic [7:0] CMD_BE   = 8'hC7;
    localparam logic [7:0] CMD_RDSR = 8'h05;

endpackage

// File: rtl/fws_spi_byte.sv
module fws_spi_byte #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic       rx_last
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        logic          busy;
        logic          sclk;
        logic [CW-1:0] cnt;
        logic [2:0]    bits;
        logic [7:0]    sh;
        logic          rx;
        logic          done;
    } eng_t;

    eng_t q_q, d_d;

    always_comb begin
        d_d      = q_q;
        d_d.done = 1'b0;
        if (!q_q.busy) begin
            if (start) begin
                d_d.busy = 1'b1;
                d_d.sh   = tx_byte;
                d_d.bits = 3'd0;
                d_d.cnt  = '0;
                d_d.sclk = 1'b0;
            end
        end else if (q_q.cnt != CW'(CLK_DIV - 1)) begin
            d_d.cnt = q_q.cnt + CW'(1);
        end else begin
            d_d.cnt = '0;
            if (!q_q.sclk) begin
                d_d.sclk = 1'b1;
                d_d.rx   = miso;
            end else begin
                d_d.sclk = 1'b0;
                d_d.sh   = {q_q.sh[6:0], 1'b0};
                d_d.bits = q_q.bits + 3'd1;
                if (q_q.bits == 3'd7) begin
                    d_d.busy = 1'b0;
                    d_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= d_d;
    end

    assign sclk    = q_q.sclk;
    assign mosi    = q_q.sh[7];
    assign busy    = q_q.busy;
    assign done    = q_q.done;
    assign rx_last = q_q.rx;

    // R6: data line is frozen while the serial clock is high
    assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.sclk |-> $stable(q_q.sh[7]));

    // R6: a clock pulse is only produced while a byte is in flight
    assert_sclk_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.sclk |-> q_q.busy);

endmodule

// File: rtl/fws_frame_hdr.sv
module fws_frame_hdr
    import fws_pkg::*;
(
    input  op_e         op,
    input  logic [23:0] addr,
    input  logic [1:0]  idx,
    output logic [7:0]  hdr_byte
);
    always_comb begin
        unique case (idx)
            2'd0: hdr_byte = (op == OP_PROG) ? CMD_PP :
                             (op == OP_SECT) ? CMD_SE : CMD_BE;
            2'd1: hdr_byte = addr[23:16];
            2'd2: hdr_byte = addr[15:8];
            default: hdr_byte = addr[7:0];
        endcase
    end
endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
    import fws_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int LEN_W   = 16,
    parameter int POLL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [23:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [POLL_W-1:0] poll_max,
    input  logic [7:0]        data_in,
    output logic              data_pop,
    output logic              done,
    output logic              err,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int GAP_CYC = 2 * CLK_DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);

    typedef struct packed {
        st_e               st;
        st_e               nxt;
        op_e               op;
        logic [23:0]       addr;
        logic [LEN_W-1:0]  rem;
        logic [2:0]        idx;
        logic [POLL_W-1:0] polls;
        logic [GW-1:0]     gap;
        logic              cs_n;
        logic              kick;
        logic [7:0]        tx;
        logic              pop;
        logic              done;
        logic              err;
    } seq_t;

    seq_t q_q, d_d;

    logic       eng_busy, eng_done, eng_rx;
    logic [7:0] hdr_byte;

    fws_spi_byte #(.CLK_DIV(CLK_DIV)) i_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (q_q.kick),
        .tx_byte (q_q.tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_last (eng_rx)
    );

    fws_frame_hdr i_hdr (
        .op       (q_q.op),
        .addr     (q_q.addr),
        .idx      (q_q.idx[1:0]),
        .hdr_byte (hdr_byte)
    );

    always_comb begin
        d_d      = q_q;
        d_d.kick = 1'b0;
        d_d.pop  = 1'b0;
        d_d.done = 1'b0;
        unique case (q_q.st)
            S_IDLE: if (req_valid) begin
                d_d.op    = op_e'(req_op);
                d_d.addr  = req_addr;
                d_d.rem   = req_len;
                d_d.polls = '0;
                d_d.err   = 1'b0;
                if (req_op == OP_BAD) begin
                    d_d.err = 1'b1;
                    d_d.st  = S_FIN;
                end else if (req_op == OP_PROG && req_len == '0) begin
                    d_d.st = S_FIN;
                end else begin
                    d_d.cs_n = 1'b0;
                    d_d.kick = 1'b1;
                    d_d.tx   = CMD_WREN;
                    d_d.st   = S_WREN;
                end
            end
            S_WREN: if (eng_done) begin
                d_d.cs_n = 1'b1;
                d_d.gap  = '0;
                d_d.idx  = 3'd0;
                d_d.nxt  = S_CMD;
                d_d.st   = S_GAP;
            end
            S_GAP: begin
                if (q_q.gap != GW'(GAP_CYC - 1)) begin
                    d_d.gap = q_q.gap + GW'(1);
                end else begin
                    d_d.st = q_q.nxt;
                    unique case (q_q.nxt)
                        S_WREN: begin
                            d_d.cs_n = 1'b0;
                            d_d.kick = 1'b1;
                            d_d.tx   = CMD_WREN;
                        end
                        S_CMD: begin
                            d_d.cs_n = 1'b0;
                            d_d.kick = 1'b1;
                            d_d.tx   = hdr_byte;
                            d_d.idx  = 3'd1;
                        end
                        S_POLL_OP: begin
                            d_d.cs_n = 1'b0;
                            d_d.kick = 1'b1;
                            d_d.tx   = CMD_RDSR;
                        end
                        default: ;
                    endcase
                end
            end
            S_CMD: if (eng_done) begin
                if (q_q.op == OP_BULK || (q_q.op == OP_SECT && q_q.idx == 3'd4)) begin
                    d_d.cs_n = 1'b1;
                    d_d.gap  = '0;
                    d_d.nxt  = S_POLL_OP;
                    d_d.st   = S_GAP;
                end else if (q_q.idx != 3'd4) begin
                    d_d.kick = 1'b1;
                    d_d.tx   = hdr_byte;
                    d_d.idx  = q_q.idx + 3'd1;
                end else begin
                    d_d.kick = 1'b1;
                    d_d.tx   = data_in;
                    d_d.pop  = 1'b1;
                    d_d.st   = S_DATA;
                end
            end
            S_DATA: if (eng_done) begin
                d_d.addr = q_q.addr + 24'd1;
                d_d.rem  = q_q.rem - LEN_W'(1);
                if (q_q.rem == LEN_W'(1) || q_q.addr[7:0] == 8'hFF) begin
                    d_d.cs_n = 1'b1;
                    d_d.gap  = '0;
                    d_d.nxt  = S_POLL_OP;
                    d_d.st   = S_GAP;
                end else begin
                    d_d.kick = 1'b1;
                    d_d.tx   = data_in;
                    d_d.pop  = 1'b1;
                end
            end
            S_POLL_OP: if (eng_done) begin
                d_d.kick = 1'b1;
                d_d.tx   = 8'h00;
                d_d.st   = S_POLL_RD;
            end
            S_POLL_RD: if (eng_done) begin
                d_d.cs_n = 1'b1;
                d_d.gap  = '0;
                if (!eng_rx) begin
                    d_d.polls = '0;
                    if (q_q.op == OP_PROG && q_q.rem != '0) begin
                        d_d.nxt = S_WREN;
                        d_d.st  = S_GAP;
                    end else begin
                        d_d.st = S_FIN;
                    end
                end else if (({1'b0, q_q.polls} + (POLL_W+1)'(1)) >= {1'b0, poll_max}) begin
                    d_d.err = 1'b1;
                    d_d.st  = S_FIN;
                end else begin
                    d_d.polls = q_q.polls + POLL_W'(1);
                    d_d.nxt   = S_POLL_OP;
                    d_d.st    = S_GAP;
                end
            end
            S_FIN: begin
                d_d.done = 1'b1;
                d_d.cs_n = 1'b1;
                d_d.gap  = '0;
                d_d.nxt  = S_IDLE;
                d_d.st   = S_GAP;
            end
            default: d_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q      <= '0;
            q_q.cs_n <= 1'b1;
        end else begin
            q_q <= d_d;
        end
    end

    assign req_ready = (q_q.st == S_IDLE);
    assign spi_cs_n  = q_q.cs_n;
    assign data_pop  = q_q.pop;
    assign done      = q_q.done;
    assign err       = q_q.err;

    // Cycles chip select has been high, saturating; used by the gap check
    logic [GW-1:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         hi_cnt_q <= GW'(GAP_CYC);
        else if (!spi_cs_n)                 hi_cnt_q <= '0;
        else if (hi_cnt_q != GW'(GAP_CYC))  hi_cnt_q <= hi_cnt_q + GW'(1);
    end

    assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_cnt_q >= GW'(GAP_CYC)));

    assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    assert_kick_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.kick |-> !eng_busy);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_pop_in_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_pop |-> (q_q.st == S_DATA && !spi_cs_n));

endmodule

// File: tb/test_flash_wr_seq.sv
module test_flash_wr_seq;
    localparam int CLK_DIV = 2;
    localparam int LEN_W   = 16;
    localparam int POLL_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = 2'd0;
    logic [23:0] req_addr = 24'd0;
    logic [LEN_W-1:0] req_len = '0;
    logic [POLL_W-1:0] poll_max = '0;
    logic [7:0] data_in = 8'd0;
    logic data_pop, done, err;
    logic spi_sclk, spi_cs_n, spi_mosi;
    logic spi_miso = 1'b0;

    always #4 clk = ~clk;

    flash_wr_seq #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W), .POLL_W(POLL_W)) i_flash_wr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .poll_max(poll_max),
        .data_in(data_in), .data_pop(data_pop), .done(done), .err(err),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 29 + 60) ^ 8'(i >> 2);
    endfunction

    // ---- expected-sequence model ----
    int ph;          // 0 expect write enable, 1 expect command, 2 polling, 3 nothing more
    int e_op;
    int e_addr;
    int e_rem;
    int d_idx;
    int cur_busy;
    int busy_left;
    int pollc;
    int dcount;

    // ---- flash bus model ----
    logic [7:0] fb [300];
    int  nb = 0;
    int  bitc = 0;
    logic [7:0] sh = 8'd0;
    logic [7:0] stat = 8'd0;
    bit  busy_now = 1'b0;
    bit  in_frame = 1'b0;
    int  hi_cyc = 1000;

    always @(negedge clk) begin
        if (spi_cs_n) hi_cyc++;
        else          hi_cyc = 0;
        if (data_pop) begin
            dcount++;
            data_in = pat(dcount);
        end
    end

    always @(negedge spi_cs_n) begin
        if (rst_n) begin
            chk(hi_cyc >= 2 * CLK_DIV, "R7 cs high time", hi_cyc, 2 * CLK_DIV);
            chk(spi_sclk == 1'b0, "R6 sclk low at cs fall", int'(spi_sclk), 0);
            in_frame = 1'b1;
            nb = 0;
            bitc = 0;
            busy_now = (busy_left > 0);
            stat = (8'($urandom) & 8'hFE) | {7'd0, busy_now};
        end
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            sh = {sh[6:0], spi_mosi};
            bitc++;
            if (bitc % 8 == 0 && nb < 300) begin
                fb[nb] = sh;
                nb++;
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n && bitc >= 8 && bitc < 16) spi_miso = stat[15 - bitc];
    end

    always @(posedge spi_cs_n) begin
        if (in_frame) begin
            in_frame = 1'b0;
            chk(bitc % 8 == 0, "R6 whole bytes", bitc, 0);
            frame_check();
        end
    end

    task automatic frame_check();
        int n;
        int derr;
        case (ph)
            0: begin
                chk(nb == 1 && fb[0] == 8'h06, "R2 write enable frame", nb == 1 ? int'(fb[0]) : nb, 6);
                ph = 1;
            end
            1: begin
                if (e_op == 0) begin
                    n = 256 - (e_addr % 256);
                    if (e_rem < n) n = e_rem;
                    chk(nb == 4 + n, "R4 program frame length", nb, 4 + n);
                    chk(fb[0] == 8'h02, "R3 program opcode", int'(fb[0]), 2);
                    chk({fb[1], fb[2], fb[3]} == 24'(e_addr), "R3 program address",
                        int'({fb[1], fb[2], fb[3]}), e_addr);
                    derr = 0;
                    for (int k = 0; k < n && 4 + k < nb; k++)
                        if (fb[4 + k] != pat(d_idx + k)) derr++;
                    chk(derr == 0, "R3 data bytes", derr, 0);
                    e_addr += n;
                    e_rem -= n;
                    d_idx += n;
                end else if (e_op == 1) begin
                    chk(nb == 4 && fb[0] == 8'hD8 && {fb[1], fb[2], fb[3]} == 24'(e_addr),
                        "R5 sector erase frame", int'({fb[0], fb[1], fb[2], fb[3]}), 32'hD8000000 | e_addr);
                end else begin
                    chk(nb == 1 && fb[0] == 8'hC7, "R5 bulk erase frame", int'(fb[0]), 8'hC7);
                end
                busy_left = cur_busy;
                pollc = 0;
                ph = 2;
            end
            2: begin
                chk(nb == 2 && fb[0] == 8'h05, "R8 status frame", int'(fb[0]), 5);
                if (busy_now) begin
                    busy_left--;
                    pollc++;
                end else begin
                    ph = (e_op == 0 && e_rem > 0) ? 0 : 3;
                end
            end
            default: chk(1'b0, "R10 unexpected frame", nb, 0);
        endcase
    endtask

    task automatic run_req(input int op, input int addr, input int len, input int busyc, input int pmax);
        bit exp_err;
        int pm_eff;
        pm_eff = (pmax == 0) ? 1 : pmax;
        e_op = op;
        e_addr = addr;
        e_rem = len;
        d_idx = 0;
        cur_busy = busyc;
        busy_left = busyc;
        pollc = 0;
        dcount = 0;
        data_in = pat(0);
        ph = (op == 3 || (op == 0 && len == 0)) ? 3 : 0;
        exp_err = (op == 3) || (ph == 0 && busyc >= pm_eff);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op = 2'(op);
        req_addr = 24'(addr);
        req_len = LEN_W'(len);
        poll_max = POLL_W'(pmax);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0 || done, "R1 ready drops after accept", int'(req_ready), 0);
        while (!done) @(negedge clk);
        chk(err == exp_err, "R9 err flag", int'(err), int'(exp_err));
        if (op == 3) chk(ph == 3, "R1 reserved op sends nothing", ph, 3);
        else if (exp_err) chk(pollc == pm_eff, "R9 busy reads before timeout", pollc, pm_eff);
        else chk(ph == 3, "R8 completed after ready status", ph, 3);
        if (op == 0 && !exp_err) chk(dcount == len, "R3 pop count", dcount, len);
        if (op == 0 && len == 0) chk(dcount == 0 && err == 1'b0, "R10 zero length", dcount, 0);
        @(negedge clk);
        chk(done == 1'b0, "R10 done is a pulse", int'(done), 0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=%0d exp=<190000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h0F1A5);
        ph = 3;
        busy_left = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R6 reset bus idle", int'({spi_cs_n, spi_sclk}), 2);
        chk(req_ready == 1'b1 && done == 1'b0 && data_pop == 1'b0, "R1 reset state",
            int'({req_ready, done, data_pop}), 4);

        // directed corner cases
        run_req(0, 24'h0012F0, 40, 2, 5);    // R4 split: 16 + 24 bytes
        run_req(0, 24'h000100, 257, 1, 4);   // R4 full page then one byte
        run_req(0, 24'h0000FF, 1, 0, 2);     // R4 last byte of a page
        run_req(0, 24'h003000, 0, 0, 2);     // R10 zero length
        run_req(3, 24'h000000, 5, 0, 2);     // R1 reserved op
        run_req(1, 24'hABCDEF, 0, 3, 3);     // R9 timeout on sector erase
        run_req(2, 24'h000000, 0, 0, 1);     // R5 bulk erase ready at once
        run_req(2, 24'h000000, 0, 5, 0);     // R9 zero limit acts as one
        run_req(0, 24'h020010, 20, 6, 4);    // R9 timeout on program
        run_req(1, 24'h7F0001, 0, 2, 8);     // R5 sector erase ok

        // constrained random
        for (int i = 0; i < 10; i++) begin
            int op;
            op = int'($urandom % 3);
            run_req(op, int'($urandom & 32'hFFFFFF), (op == 0) ? int'($urandom % 180) + 1 : 0,
                    int'($urandom % 4), 8);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        if (seed_unused_guard) $display("unused");
    end
    localparam bit seed_unused_guard = 1'b0;

endmodule